// File: doc/BRIEF.md
# Clock Source Selection Controller

This controller sits beside the clock tree of a small microcontroller and decides which source feeds the core and peripherals. It holds the programmable control bits and drives the select lines for the external-input halving stage, the crystal divide-by-16 path, the PLL path and the alternate clock. It also drives the PLL multiplier and post-divider values and the CPU clock prescaler ratio. The analog PLL, the oscillator and the glitch-free switching cells sit outside and only see these selects and enables.

Software programs three control registers through a simple synchronous write port and reads them, plus a live status word, through a combinational read port. A state machine follows wait-for-interrupt entry and interrupt wakeup. On entry it can force low-power operation and, if the alternate clock is present, switch to it. On wakeup it restores the earlier choice. The crystal-stop request is gated so the crystal can only be stopped while the alternate clock is present and actually in use. If the alternate clock disappears, the controller falls back to the crystal path on the next cycle.

The state machine has three states. `ST_RUN` is normal operation. `ST_WAIT` is waiting for an interrupt with the clock choice unchanged. `ST_WAIT_ALT` is waiting for an interrupt with the alternate clock forced. Its transitions are:
- ENTER_KEEP: `ST_RUN` to `ST_WAIT`, on WFI entry when the alternate clock is not requested or is absent.
- ENTER_ALT: `ST_RUN` to `ST_WAIT_ALT`, on WFI entry when the alternate clock is requested and present.
- WAKE: `ST_WAIT` or `ST_WAIT_ALT` to `ST_RUN`, on an interrupt wakeup.
- DROP: `ST_WAIT_ALT` to `ST_WAIT`, when the alternate clock disappears without a wakeup.

Top module: `clksel_ctrl`

## Requirements
- R1: After reset every register bit is 0. The outputs then show no halving, PLL and crystal /16 deselected, alternate clock deselected, multiplier 6, divider 1, prescaler 1, no low power and no crystal stop.
- R2: Bit 0 of register 0 (`half_in`) drives `half_sel`, which halves the external input clock.
- R3: Register 1 bits [1:0] are the multiplier code. Codes 00, 01, 10 and 11 give `pll_mul` = 6, 8, 10 and 14.
- R4: Register 1 bits [4:2] are the post-divider code, with `pll_div` = code+1. Register 0 bits [3:1] are the prescaler code, with `cpu_presc` = code+1.
- R5: Source priority is alternate clock, then crystal /16 (register 2 bit 0), then PLL (register 1 bit 5), then the direct crystal. At most one of `alt_sel`, `xt16_sel` and `pll_sel` is high.
- R6: When register 2 bit 2 (low-power-on-WFI) is set, WFI entry in `ST_RUN` raises `low_power` from the next cycle until wakeup. Register 2 bit 4 forces `low_power` at any time.
- R7: When register 2 bit 3 (alternate-on-WFI) is set and `alt_present` is high, WFI entry selects the alternate clock from the next cycle. If the bit is clear or the alternate clock is absent, the selection is unchanged.
- R8: `xtal_stop` is high exactly when `alt_present` is high and the alternate clock is selected. Otherwise it is low in the same cycle.
- R9: An interrupt wakeup during WFI returns to `ST_RUN` on the next cycle and restores the pre-entry source selection and power mode.
- R10: If `alt_present` is low while the alternate clock is selected, the next cycle selects the crystal-based path. Both the software select bit (register 2 bit 1) and any WFI override are cleared.
- R11: Reads of addresses 0 to 2 return the written bits: register 0 bits [3:0], register 1 bits [5:0], register 2 bits [4:0]. Address 3 returns status: bit 0 `alt_present`, bit 1 alternate selected, bit 2 `xtal_stop`, bit 3 waiting for interrupt, bit 4 `low_power`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| wfi_enter | input | 1 | Single-cycle wait-for-interrupt entry pulse |
| wake_irq | input | 1 | Interrupt wakeup |
| alt_present | input | 1 | Alternate clock is running |
| half_sel | output | 1 | Halve the external input clock |
| cpu_presc | output | 4 | CPU clock prescaler ratio |
| pll_mul | output | 4 | PLL multiplication factor |
| pll_div | output | 4 | PLL post-divider ratio |
| pll_sel | output | 1 | Select the PLL path |
| xt16_sel | output | 1 | Select the crystal /16 path |
| alt_sel | output | 1 | Select the alternate clock |
| low_power | output | 1 | Low-power operation indication |
| xtal_stop | output | 1 | Request to stop the crystal oscillator |

## Verification
The hardest case to reach is the loss of the alternate clock while the state machine is in `ST_WAIT_ALT`. There, `xtal_stop` must drop in the same cycle while the alternate select persists for exactly one more cycle. The stimulus first programs both WFI options, pulses WFI entry with the alternate clock present, and then lowers `alt_present` just after a clock edge. The outputs are sampled before and after the next edge to catch the one-cycle window. The same single-cycle window is also checked for a software-selected alternate clock outside WFI.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 2;
    localparam int CODE_W     = 3;
    localparam int RATIO_W    = 4;

    localparam logic [ADDR_W-1:0] A_DIV    = 2'd0;
    localparam logic [ADDR_W-1:0] A_PLL    = 2'd1;
    localparam logic [ADDR_W-1:0] A_SEL    = 2'd2;
    localparam logic [ADDR_W-1:0] A_STATUS = 2'd3;

    localparam logic [DATA_W-1:0] MASK_DIV = 8'h0F;
    localparam logic [DATA_W-1:0] MASK_PLL = 8'h3F;
    localparam logic [DATA_W-1:0] MASK_SEL = 8'h1F;

    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_WAIT     = 2'd1,
        ST_WAIT_ALT = 2'd2
    } wfi_state_e;

    typedef struct packed {
        logic              half_in;
        logic [CODE_W-1:0] presc_code;
        logic [1:0]        mul_code;
        logic [CODE_W-1:0] div_code;
        logic              pll_en;
        logic              xt16;
        logic              alt_sw;
        logic              lp_on_wfi;
        logic              alt_on_wfi;
        logic              lp_mode;
    } ctl_t;

endpackage

// File: rtl/clksel_regs.sv
module clksel_regs
    import clksel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              alt_present,
    input  logic [DATA_W-1:0] status,
    output logic [DATA_W-1:0] rd_data,
    output ctl_t              ctl
);

    logic [DATA_W-1:0] div_q, pll_q, sel_q;
    logic [DATA_W-1:0] sel_d;

    // register 2 next value: software write first, then alternate-loss clear
    always_comb begin
        sel_d = sel_q;
        if (wr_en && wr_addr == A_SEL) begin
            sel_d = wr_data & MASK_SEL;
        end
        if (!alt_present) begin
            sel_d[1] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            pll_q <= '0;
            sel_q <= '0;
        end else begin
            if (wr_en && wr_addr == A_DIV) begin
                div_q <= wr_data & MASK_DIV;
            end
            if (wr_en && wr_addr == A_PLL) begin
                pll_q <= wr_data & MASK_PLL;
            end
            sel_q <= sel_d;
        end
    end

    always_comb begin
        unique case (rd_addr)
            A_DIV:    rd_data = div_q;
            A_PLL:    rd_data = pll_q;
            A_SEL:    rd_data = sel_q;
            A_STATUS: rd_data = status;
            default:  rd_data = '0;
        endcase
    end

    always_comb begin
        ctl.half_in    = div_q[0];
        ctl.presc_code = div_q[3:1];
        ctl.mul_code   = pll_q[1:0];
        ctl.div_code   = pll_q[4:2];
        ctl.pll_en     = pll_q[5];
        ctl.xt16       = sel_q[0];
        ctl.alt_sw     = sel_q[1];
        ctl.lp_on_wfi  = sel_q[2];
        ctl.alt_on_wfi = sel_q[3];
        ctl.lp_mode    = sel_q[4];
    end

endmodule

// File: rtl/clksel_fsm.sv
module clksel_fsm
    import clksel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wfi_enter,
    input  logic wake_irq,
    input  logic alt_present,
    input  logic alt_on_wfi,
    input  logic lp_on_wfi,
    output logic waiting,
    output logic alt_force,
    output logic lp_force
);

    wfi_state_e state_q, state_d;
    logic       lp_hold_q, lp_hold_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_RUN;
            lp_hold_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            lp_hold_q <= lp_hold_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        lp_hold_d = lp_hold_q;
        unique case (state_q)
            ST_RUN: begin
                if (wfi_enter) begin
                    lp_hold_d = lp_on_wfi;
                    if (alt_on_wfi && alt_present) begin
                        state_d = ST_WAIT_ALT;       // ENTER_ALT
                    end else begin
                        state_d = ST_WAIT;           // ENTER_KEEP
                    end
                end
            end
            ST_WAIT: begin
                if (wake_irq) begin
                    state_d   = ST_RUN;              // WAKE
                    lp_hold_d = 1'b0;
                end
            end
            ST_WAIT_ALT: begin
                if (wake_irq) begin
                    state_d   = ST_RUN;              // WAKE
                    lp_hold_d = 1'b0;
                end else if (!alt_present) begin
                    state_d = ST_WAIT;               // DROP
                end
            end
            default: begin
                state_d   = ST_RUN;
                lp_hold_d = 1'b0;
            end
        endcase
    end

    always_comb begin
        waiting   = 1'b0;
        alt_force = 1'b0;
        unique case (state_q)
            ST_RUN:      begin waiting = 1'b0; alt_force = 1'b0; end
            ST_WAIT:     begin waiting = 1'b1; alt_force = 1'b0; end
            ST_WAIT_ALT: begin waiting = 1'b1; alt_force = 1'b1; end
            default:     begin waiting = 1'b0; alt_force = 1'b0; end
        endcase
        lp_force = waiting & lp_hold_q;
    end

endmodule

// File: rtl/clksel_ratio.sv
module clksel_ratio
    import clksel_pkg::*;
(
    input  logic [1:0]         mul_code,
    input  logic [CODE_W-1:0]  div_code,
    input  logic [CODE_W-1:0]  presc_code,
    output logic [RATIO_W-1:0] pll_mul,
    output logic [RATIO_W-1:0] pll_div,
    output logic [RATIO_W-1:0] cpu_presc
);

    localparam int PAD_W = RATIO_W - CODE_W;

    always_comb begin
        unique case (mul_code)
            2'b00:   pll_mul = RATIO_W'(6);
            2'b01:   pll_mul = RATIO_W'(8);
            2'b10:   pll_mul = RATIO_W'(10);
            2'b11:   pll_mul = RATIO_W'(14);
            default: pll_mul = RATIO_W'(6);
        endcase
    end

    assign pll_div   = {{PAD_W{1'b0}}, div_code}   + RATIO_W'(1);
    assign cpu_presc = {{PAD_W{1'b0}}, presc_code} + RATIO_W'(1);

endmodule

// File: rtl/clksel_ctrl.sv
module clksel_ctrl
    import clksel_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic [1:0]  rd_addr,
    output logic [7:0]  rd_data,
    input  logic        wfi_enter,
    input  logic        wake_irq,
    input  logic        alt_present,
    output logic        half_sel,
    output logic [3:0]  cpu_presc,
    output logic [3:0]  pll_mul,
    output logic [3:0]  pll_div,
    output logic        pll_sel,
    output logic        xt16_sel,
    output logic        alt_sel,
    output logic        low_power,
    output logic        xtal_stop
);

    ctl_t              ctl;
    logic              waiting, alt_force, lp_force;
    logic              alt_eff;
    logic [DATA_W-1:0] status;
    logic              lp_on_wfi, alt_on_wfi;

    assign lp_on_wfi  = ctl.lp_on_wfi;
    assign alt_on_wfi = ctl.alt_on_wfi;

    clksel_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .alt_present (alt_present),
        .status      (status),
        .rd_data     (rd_data),
        .ctl         (ctl)
    );

    clksel_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wfi_enter   (wfi_enter),
        .wake_irq    (wake_irq),
        .alt_present (alt_present),
        .alt_on_wfi  (alt_on_wfi),
        .lp_on_wfi   (lp_on_wfi),
        .waiting     (waiting),
        .alt_force   (alt_force),
        .lp_force    (lp_force)
    );

    clksel_ratio u_ratio (
        .mul_code   (ctl.mul_code),
        .div_code   (ctl.div_code),
        .presc_code (ctl.presc_code),
        .pll_mul    (pll_mul),
        .pll_div    (pll_div),
        .cpu_presc  (cpu_presc)
    );

    // source priority: alternate, crystal /16, PLL, direct crystal
    always_comb begin
        alt_eff   = ctl.alt_sw | alt_force;
        alt_sel   = alt_eff;
        xt16_sel  = ctl.xt16 & ~alt_eff;
        pll_sel   = ctl.pll_en & ~ctl.xt16 & ~alt_eff;
        half_sel  = ctl.half_in;
        low_power = ctl.lp_mode | lp_force;
        xtal_stop = alt_eff & alt_present;
        status    = {3'b000, low_power, waiting, xtal_stop, alt_eff, alt_present};
    end

endmodule

// File: rtl/clksel_ctrl_chk.sv
module clksel_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wfi_enter,
    input logic       wake_irq,
    input logic       alt_present,
    input logic       waiting,
    input logic       lp_on_wfi,
    input logic       alt_on_wfi,
    input logic [3:0] pll_mul,
    input logic       pll_sel,
    input logic       xt16_sel,
    input logic       alt_sel,
    input logic       low_power,
    input logic       xtal_stop
);

    p_mul_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_mul == 4'd6) || (pll_mul == 4'd8) || (pll_mul == 4'd10) || (pll_mul == 4'd14));

    p_src_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({alt_sel, xt16_sel, pll_sel}));

    p_lp_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!waiting && wfi_enter && lp_on_wfi) |=> low_power);

    p_alt_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!waiting && wfi_enter && alt_on_wfi && alt_present) |=> alt_sel);

    p_xtal_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xtal_stop |-> (alt_present && alt_sel));

    p_wake_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && wake_irq) |=> !waiting);

    p_alt_fallback_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_sel && !alt_present) |=> !alt_sel);

endmodule

bind clksel_ctrl clksel_ctrl_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wfi_enter   (wfi_enter),
    .wake_irq    (wake_irq),
    .alt_present (alt_present),
    .waiting     (waiting),
    .lp_on_wfi   (lp_on_wfi),
    .alt_on_wfi  (alt_on_wfi),
    .pll_mul     (pll_mul),
    .pll_sel     (pll_sel),
    .xt16_sel    (xt16_sel),
    .alt_sel     (alt_sel),
    .low_power   (low_power),
    .xtal_stop   (xtal_stop)
);

// File: tb/clksel_ctrl_tb_top.sv
module clksel_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       wfi_enter = 1'b0;
    logic       wake_irq = 1'b0;
    logic       alt_present = 1'b0;
    logic       half_sel, pll_sel, xt16_sel, alt_sel, low_power, xtal_stop;
    logic [3:0] cpu_presc, pll_mul, pll_div;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    typedef struct {
        string       tag;
        logic [25:0] exp;
    } item_t;

    item_t q[$];

    always #5 clk = ~clk;

    clksel_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .wfi_enter(wfi_enter), .wake_irq(wake_irq), .alt_present(alt_present),
        .half_sel(half_sel), .cpu_presc(cpu_presc), .pll_mul(pll_mul),
        .pll_div(pll_div), .pll_sel(pll_sel), .xt16_sel(xt16_sel),
        .alt_sel(alt_sel), .low_power(low_power), .xtal_stop(xtal_stop)
    );

    function automatic logic [25:0] mk(input logic h, input logic [3:0] pr,
        input logic [3:0] mu, input logic [3:0] dv, input logic pl,
        input logic x16, input logic al, input logic lp, input logic xs,
        input logic [7:0] rd);
        return {h, pr, mu, dv, pl, x16, al, lp, xs, rd};
    endfunction

    // monitor: pops one expected item per falling edge and compares
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t e;
            logic [25:0] got;
            e   = q.pop_front();
            got = {half_sel, cpu_presc, pll_mul, pll_div, pll_sel, xt16_sel,
                   alt_sel, low_power, xtal_stop, rd_data};
            checks++;
            if (got !== e.exp) begin
                errors++;
                $display("FAIL %s: got %h expected %h", e.tag, got, e.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input string tag, input logic [25:0] v);
        q.push_back('{tag, v});
        @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic pulse_wfi();
        wfi_enter = 1'b1;
        tick();
        wfi_enter = 1'b0;
    endtask

    task automatic pulse_wake();
        wake_irq = 1'b1;
        tick();
        wake_irq = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        // R1 reset state
        rd_addr = 2'd3;
        expect_out("R1 reset", mk(0, 1, 6, 1, 0, 0, 0, 0, 0, 8'h00));
        // R2 / R11 halving bit
        wr(2'd0, 8'h01); rd_addr = 2'd0;
        expect_out("R2 half", mk(1, 1, 6, 1, 0, 0, 0, 0, 0, 8'h01));
        // R4 prescaler code 5 -> 6, unused bits dropped (R11)
        wr(2'd0, 8'hFB);
        expect_out("R4 presc", mk(1, 6, 6, 1, 0, 0, 0, 0, 0, 8'h0B));
        // R3 multiplier codes, R4 divider code 3 -> 4
        rd_addr = 2'd1;
        for (int m = 0; m < 4; m++) begin
            logic [3:0] mv;
            mv = (m == 0) ? 4'd6 : (m == 1) ? 4'd8 : (m == 2) ? 4'd10 : 4'd14;
            wr(2'd1, 8'h2C | 8'(m));
            expect_out("R3 mul", mk(1, 6, mv, 4, 1, 0, 0, 0, 0, 8'h2C | 8'(m)));
        end
        // R5 crystal /16 over PLL
        wr(2'd2, 8'h01); rd_addr = 2'd2;
        expect_out("R5 xt16", mk(1, 6, 14, 4, 0, 1, 0, 0, 0, 8'h01));
        // R5 / R8 software alternate with clock present
        alt_present = 1'b1;
        wr(2'd2, 8'h03); rd_addr = 2'd3;
        expect_out("R8 alt stop", mk(1, 6, 14, 4, 0, 0, 1, 0, 1, 8'h07));
        // R8 / R10 alternate clock lost
        tick(); alt_present = 1'b0;
        expect_out("R8 same cycle", mk(1, 6, 14, 4, 0, 0, 1, 0, 0, 8'h02));
        tick(); rd_addr = 2'd2;
        expect_out("R10 fallback", mk(1, 6, 14, 4, 0, 1, 0, 0, 0, 8'h01));
        // R6 / R7 / R9 WFI with both options
        alt_present = 1'b1;
        wr(2'd2, 8'h0C); rd_addr = 2'd3;
        expect_out("R9 before", mk(1, 6, 14, 4, 1, 0, 0, 0, 0, 8'h01));
        pulse_wfi();
        expect_out("R7 alt on wfi", mk(1, 6, 14, 4, 0, 0, 1, 1, 1, 8'h1F));
        pulse_wake();
        expect_out("R9 restore", mk(1, 6, 14, 4, 1, 0, 0, 0, 0, 8'h01));
        // R7 alternate absent: selection unchanged, R6 low power still
        alt_present = 1'b0;
        pulse_wfi();
        expect_out("R7 absent", mk(1, 6, 14, 4, 1, 0, 0, 1, 0, 8'h18));
        pulse_wake();
        expect_out("R9 lp off", mk(1, 6, 14, 4, 1, 0, 0, 0, 0, 8'h00));
        // R10 loss of alternate clock inside WFI
        alt_present = 1'b1;
        pulse_wfi();
        expect_out("R7 enter", mk(1, 6, 14, 4, 0, 0, 1, 1, 1, 8'h1F));
        tick(); alt_present = 1'b0;
        expect_out("R8 wfi loss", mk(1, 6, 14, 4, 0, 0, 1, 1, 0, 8'h1A));
        tick();
        expect_out("R10 wfi fallback", mk(1, 6, 14, 4, 1, 0, 0, 1, 0, 8'h18));
        pulse_wake();
        expect_out("R9 wake", mk(1, 6, 14, 4, 1, 0, 0, 0, 0, 8'h00));
        // R7 alternate-on-WFI clear: no switch even if present
        alt_present = 1'b1;
        wr(2'd2, 8'h04);
        pulse_wfi();
        expect_out("R7 disabled", mk(1, 6, 14, 4, 1, 0, 0, 1, 0, 8'h19));
        pulse_wake();
        // R6 software low-power bit
        wr(2'd2, 8'h10); rd_addr = 2'd2;
        expect_out("R6 sw lp", mk(1, 6, 14, 4, 1, 0, 0, 1, 0, 8'h10));
        tick();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule